// File: doc/BRIEF.md
# Four-Read Two-Write Bypassed Floating-Point Register File

This block holds the floating-point general registers of a dual-issue pipeline: thirty-two 64-bit entries, four read ports and two write ports. Read ports 0, 1 and 2 supply the three operands of the arithmetic pipe, so a fused multiply-add can fetch all of its sources in one cycle. Read port 3 supplies store data and the source for conditional moves. One write port takes results from the arithmetic pipe. The other takes load data and move results, and it can work in the same cycle as the arithmetic port.

Reads are combinational. Each write is committed on the rising clock edge. A read that names a register being written in the same cycle returns the incoming value instead of the stored one. The arithmetic write has priority, then the load/move write, then the stored contents. When both write ports name the same register, the arithmetic result is the one kept and a conflict flag rises for that cycle. A 64-bit load writes the whole register in one cycle.

Reset is active low and asynchronous. It is released through a two-stage synchronizer, and it clears every register to zero.

Top module: `fprf_top`

## Requirements
- R1: After reset is released, every one of the 32 registers reads as zero on every read port.
- R2: A write accepted on either write port is stored at the rising edge and reads back the full 64-bit value in every later cycle until that register is written again.
- R3: The four read ports are independent. Each port returns the value of the register its own address names, in the same cycle, whatever the other ports address.
- R4: When the arithmetic write port is enabled and its address equals a read port's address, that read port returns the arithmetic write data in the same cycle.
- R5: When the load/move write port is enabled and its address equals a read port's address, and no enabled arithmetic write names that register, that read port returns the load/move write data in the same cycle.
- R6: When both write ports are enabled with equal addresses, every read port addressing that register returns the arithmetic write data.
- R7: When both write ports are enabled with equal addresses, the register keeps the arithmetic write data after the edge.
- R8: `wr_clash_o` is 1 in exactly the cycles in which both write enables are 1 and the two write addresses are equal. It is 0 otherwise, including when both writes target different registers.
- R9: A write port whose enable is 0 has no effect, whatever its address and data. The addressed register keeps its old value, and reads of it return that value.
- R10: Two enabled writes to different registers in one cycle are both stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rd_addr_i | input | 4x5 | Read addresses; index 0-2 arithmetic operands, index 3 store/move |
| rd_data_o | output | 4x64 | Read data with bypass, one 64-bit lane per read port |
| wa_en_i | input | 1 | Arithmetic write enable |
| wa_addr_i | input | 5 | Arithmetic write register |
| wa_data_i | input | 64 | Arithmetic write data |
| wm_en_i | input | 1 | Load/move write enable |
| wm_addr_i | input | 5 | Load/move write register |
| wm_data_i | input | 64 | Load/move write data |
| wr_clash_o | output | 1 | Both write ports target the same register this cycle |

## Verification
The assertions assume that every address is below the register count and that inputs settle before the rising edge. They also assume that write enables are low while the synchronized reset is active, because the persistence and hold checks compare against the previous cycle only after a cycle that was out of reset. The bench keeps to these assumptions. It draws addresses from the 5-bit range only, changes inputs on the falling edge, and holds both enables at 0 through reset and the synchronizer delay. Random traffic is weighted towards a few low register numbers, so that bypass hits, write clashes and back-to-back overwrites occur often.

// File: rtl/fprf_pkg.sv
package fprf_pkg;

  localparam int FPRF_REGS     = 32;
  localparam int FPRF_DATA_W   = 64;
  localparam int FPRF_RD_PORTS = 4;
  localparam int FPRF_ADDR_W   = $clog2(FPRF_REGS);

  // where a read port takes its value from, in falling priority
  typedef enum logic [1:0] {
    SRC_ARITH = 2'd0,
    SRC_MEM   = 2'd1,
    SRC_STORE = 2'd2
  } fprf_src_e;

endpackage

// File: rtl/fprf_rst_sync.sv
module fprf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_s_n = sync_q[STAGES-1];

endmodule

// File: rtl/fprf_store.sv
module fprf_store #(
  parameter int REGS   = 32,
  parameter int DATA_W = 64,
  parameter int ADDR_W = $clog2(REGS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wa_en_i,
  input  logic [ADDR_W-1:0]            wa_addr_i,
  input  logic [DATA_W-1:0]            wa_data_i,
  input  logic                         wm_en_i,
  input  logic [ADDR_W-1:0]            wm_addr_i,
  input  logic [DATA_W-1:0]            wm_data_i,
  output logic [REGS-1:0][DATA_W-1:0]  regs_o,
  output logic                         conflict_o
);

  logic [REGS-1:0]              hit_a;
  logic [REGS-1:0]              hit_m;
  logic [REGS-1:0]              reg_ce;
  logic [REGS-1:0][DATA_W-1:0]  reg_d;
  logic [REGS-1:0][DATA_W-1:0]  reg_q;
  logic                         run_q;

  assign conflict_o = wa_en_i && wm_en_i && (wa_addr_i == wm_addr_i);

  genvar gi;
  generate
    for (gi = 0; gi < REGS; gi++) begin : g_entry
      always_comb begin
        hit_a[gi]  = wa_en_i && (wa_addr_i == ADDR_W'(gi));
        hit_m[gi]  = wm_en_i && (wm_addr_i == ADDR_W'(gi)) && !hit_a[gi];
        reg_ce[gi] = hit_a[gi] || hit_m[gi];
        reg_d[gi]  = hit_a[gi] ? wa_data_i : wm_data_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          reg_q[gi] <= '0;
        end else if (reg_ce[gi]) begin
          reg_q[gi] <= reg_d[gi];
        end
      end
    end
  endgenerate

  assign regs_o = reg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
    end
  end

  // R7: same-register clash keeps the arithmetic result
  assert_arith_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(wa_en_i && wm_en_i && (wa_addr_i == wm_addr_i)))
      |-> (reg_q[$past(wa_addr_i)] == $past(wa_data_i)));

  // R9: no enabled write leaves all storage untouched
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(!wa_en_i && !wm_en_i)) |-> (reg_q == $past(reg_q)));

  // R10: distinct-register writes both land
  assert_dual_land_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(wa_en_i && wm_en_i && (wa_addr_i != wm_addr_i)))
      |-> (reg_q[$past(wm_addr_i)] == $past(wm_data_i)));

endmodule

// File: rtl/fprf_bypass.sv
module fprf_bypass
  import fprf_pkg::*;
#(
  parameter int REGS   = 32,
  parameter int DATA_W = 64,
  parameter int ADDR_W = $clog2(REGS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            raddr_i,
  input  logic [REGS-1:0][DATA_W-1:0]  regs_i,
  input  logic                         wa_en_i,
  input  logic [ADDR_W-1:0]            wa_addr_i,
  input  logic [DATA_W-1:0]            wa_data_i,
  input  logic                         wm_en_i,
  input  logic [ADDR_W-1:0]            wm_addr_i,
  input  logic [DATA_W-1:0]            wm_data_i,
  output logic [DATA_W-1:0]            rdata_o
);

  fprf_src_e src;

  always_comb begin
    if (wa_en_i && (wa_addr_i == raddr_i)) begin
      src = SRC_ARITH;
    end else if (wm_en_i && (wm_addr_i == raddr_i)) begin
      src = SRC_MEM;
    end else begin
      src = SRC_STORE;
    end
  end

  always_comb begin
    case (src)
      SRC_ARITH: rdata_o = wa_data_i;
      SRC_MEM:   rdata_o = wm_data_i;
      default:   rdata_o = regs_i[raddr_i];
    endcase
  end

  // R5: load/move data forwarded when arithmetic port does not hit
  assert_mem_fwd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wm_en_i && (wm_addr_i == raddr_i) && !(wa_en_i && (wa_addr_i == raddr_i)))
      |-> (rdata_o == wm_data_i));

  // R3: with no write hit the port shows the stored entry
  assert_plain_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wa_en_i && (wa_addr_i == raddr_i)) && !(wm_en_i && (wm_addr_i == raddr_i)))
      |-> (rdata_o == regs_i[raddr_i]));

endmodule

// File: rtl/fprf_top.sv
module fprf_top
  import fprf_pkg::*;
#(
  parameter int REGS     = FPRF_REGS,
  parameter int DATA_W   = FPRF_DATA_W,
  parameter int RD_PORTS = FPRF_RD_PORTS,
  parameter int ADDR_W   = $clog2(REGS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [RD_PORTS-1:0][ADDR_W-1:0]  rd_addr_i,
  output logic [RD_PORTS-1:0][DATA_W-1:0]  rd_data_o,
  input  logic                             wa_en_i,
  input  logic [ADDR_W-1:0]                wa_addr_i,
  input  logic [DATA_W-1:0]                wa_data_i,
  input  logic                             wm_en_i,
  input  logic [ADDR_W-1:0]                wm_addr_i,
  input  logic [DATA_W-1:0]                wm_data_i,
  output logic                             wr_clash_o
);

  logic                         rst_s_n;
  logic [REGS-1:0][DATA_W-1:0]  regs;
  logic                         live_q;

  fprf_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  fprf_store #(.REGS(REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .wa_en_i    (wa_en_i),
    .wa_addr_i  (wa_addr_i),
    .wa_data_i  (wa_data_i),
    .wm_en_i    (wm_en_i),
    .wm_addr_i  (wm_addr_i),
    .wm_data_i  (wm_data_i),
    .regs_o     (regs),
    .conflict_o (wr_clash_o)
  );

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      live_q <= 1'b0;
    end else begin
      live_q <= 1'b1;
    end
  end

  genvar gp;
  generate
    for (gp = 0; gp < RD_PORTS; gp++) begin : g_rd
      fprf_bypass #(.REGS(REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_byp (
        .clk       (clk),
        .rst_n     (rst_s_n),
        .raddr_i   (rd_addr_i[gp]),
        .regs_i    (regs),
        .wa_en_i   (wa_en_i),
        .wa_addr_i (wa_addr_i),
        .wa_data_i (wa_data_i),
        .wm_en_i   (wm_en_i),
        .wm_addr_i (wm_addr_i),
        .wm_data_i (wm_data_i),
        .rdata_o   (rd_data_o[gp])
      );

      // R4 / R6: arithmetic write reaches this port in the same cycle
      assert_arith_fwd_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
        (wa_en_i && (wa_addr_i == rd_addr_i[gp])) |-> (rd_data_o[gp] == wa_data_i));

      // R2: an arithmetic write reads back on the next quiet cycle
      assert_persist_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
        (live_q && $past(wa_en_i) && !wa_en_i && !wm_en_i
          && (rd_addr_i[gp] == $past(wa_addr_i)))
          |-> (rd_data_o[gp] == $past(wa_data_i)));
    end
  endgenerate

  // R8: clash flag only while both write ports are active
  assert_clash_needs_both_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    wr_clash_o |-> (wa_en_i && wm_en_i));

endmodule

// File: tb/tb_fprf_top.sv
module tb_fprf_top;

  localparam int CLK_PERIOD = 10;
  localparam int REGS = 32;
  localparam int DW   = 64;
  localparam int AW   = 5;
  localparam int RP   = 4;

  logic                   clk = 1'b0;
  logic                   rst_n;
  logic [RP-1:0][AW-1:0]  rd_addr;
  logic [RP-1:0][DW-1:0]  rd_data;
  logic                   wa_en, wm_en;
  logic [AW-1:0]          wa_addr, wm_addr;
  logic [DW-1:0]          wa_data, wm_data;
  logic                   clash;

  logic [DW-1:0] model [REGS];
  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  fprf_top dut (
    .clk (clk), .rst_n (rst_n),
    .rd_addr_i (rd_addr), .rd_data_o (rd_data),
    .wa_en_i (wa_en), .wa_addr_i (wa_addr), .wa_data_i (wa_data),
    .wm_en_i (wm_en), .wm_addr_i (wm_addr), .wm_data_i (wm_data),
    .wr_clash_o (clash)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] exp_rd(logic [AW-1:0] a);
    if (wa_en && wa_addr == a) return wa_data;
    if (wm_en && wm_addr == a) return wm_data;
    return model[a];
  endfunction

  task automatic chk64(string tag, int port, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s port %0d actual=%h expected=%h", tag, port, act, exp);
    end
  endtask

  task automatic chk1(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s clash actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic quiet();
    wa_en = 0; wm_en = 0;
  endtask

  // called just after a falling edge with inputs already set
  task automatic cycle(string rtag, string ctag);
    #1;
    for (int p = 0; p < RP; p++) chk64(rtag, p, rd_data[p], exp_rd(rd_addr[p]));
    chk1(ctag, clash, wa_en && wm_en && (wa_addr == wm_addr));
    @(posedge clk);
    if (wm_en) model[wm_addr] = wm_data;
    if (wa_en) model[wa_addr] = wa_data;
    @(negedge clk);
  endtask

  task automatic all_ports(logic [AW-1:0] a);
    for (int p = 0; p < RP; p++) rd_addr[p] = a;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < REGS; i++) model[i] = '0;
    rst_n = 0; quiet();
    wa_addr = 0; wm_addr = 0; wa_data = 0; wm_data = 0;
    rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: all registers zero after reset
    for (int b = 0; b < REGS / RP; b++) begin
      for (int p = 0; p < RP; p++) rd_addr[p] = AW'(b * RP + p);
      cycle("R1", "R8");
    end

    // R2: write on each port, read back later
    wm_en = 1; wm_addr = 5; wm_data = 64'hDEAD_BEEF_0123_4567;
    rd_addr = '0; cycle("R2", "R8");
    quiet(); wa_en = 1; wa_addr = 9; wa_data = 64'hFFFF_0000_FFFF_0001;
    cycle("R2", "R8");
    quiet(); rd_addr[0] = 5; rd_addr[1] = 9; rd_addr[2] = 5; rd_addr[3] = 9;
    cycle("R2", "R8");
    cycle("R2", "R8");

    // R4: arithmetic bypass to all ports
    wa_en = 1; wa_addr = 3; wa_data = 64'h1111_2222_3333_4444;
    all_ports(3); cycle("R4", "R8");
    quiet(); cycle("R2", "R8");

    // R5: load/move bypass to all ports
    wm_en = 1; wm_addr = 7; wm_data = 64'h8000_0000_0000_0001;
    all_ports(7); cycle("R5", "R8");
    quiet(); cycle("R2", "R8");

    // R6 and R8: same-register clash
    wa_en = 1; wa_addr = 12; wa_data = 64'hAAAA_AAAA_AAAA_AAAA;
    wm_en = 1; wm_addr = 12; wm_data = 64'h5555_5555_5555_5555;
    all_ports(12); cycle("R6", "R8");
    // R7: arithmetic value stored
    quiet(); cycle("R7", "R8");

    // R8 and R10: different registers both enabled
    wa_en = 1; wa_addr = 20; wa_data = 64'h0F0F_0F0F_0F0F_0F0F;
    wm_en = 1; wm_addr = 21; wm_data = 64'hF0F0_F0F0_F0F0_F0F0;
    rd_addr[0] = 20; rd_addr[1] = 21; rd_addr[2] = 20; rd_addr[3] = 21;
    cycle("R10", "R8");
    quiet(); cycle("R10", "R8");

    // R9: disabled ports with live address and data
    wa_addr = 3; wa_data = 64'hBAD0_BAD0_BAD0_BAD0;
    wm_addr = 7; wm_data = 64'hBAD1_BAD1_BAD1_BAD1;
    rd_addr[0] = 3; rd_addr[1] = 7; rd_addr[2] = 3; rd_addr[3] = 7;
    cycle("R9", "R8");
    cycle("R9", "R8");

    // R3: random independent traffic, biased to low registers
    for (int n = 0; n < 1500; n++) begin
      wa_en = 1'($urandom);
      wm_en = 1'($urandom);
      wa_addr = ($urandom % 4 == 0) ? AW'($urandom) : AW'($urandom % 6);
      wm_addr = ($urandom % 4 == 0) ? AW'($urandom) : AW'($urandom % 6);
      wa_data = {$urandom, $urandom};
      wm_data = {$urandom, $urandom};
      for (int p = 0; p < RP; p++)
        rd_addr[p] = ($urandom % 3 == 0) ? AW'($urandom) : AW'($urandom % 6);
      cycle("R3", "R8");
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule